// File: doc/BRIEF.md
# Multicycle Core Selector Crossbar

The crossbar sits between a host-side bus interface and a bank of register-mapped cores. The host side runs at half the rate of the crossbar and the cores. Both clocks come from one source and their edges line up. The crossbar itself runs only on the fast clock. The host holds every request (select, write flag, address, write data) for one slow cycle, which is two fast cycles.

The upper field of the host address names a core, and the lower field is a register offset that passes to that core unchanged. Each core has its own set of registered select, write-flag, offset and write-data lines. These registers can be placed near their core, which keeps the broadcast paths short. A core number with no populated core behind it matches no core, so a write to it is lost.

On the return path, the core number goes through two fast-clock register stages. That delayed copy drives a wide multiplexer over the read buses of all cores. The multiplexer result is captured in a read-data register that feeds the host side. The host samples its read data one slow cycle after the request, so the multiplexer is given two fast cycles to settle.

Top module: `core_selector_xbar`

## Requirements
- R1: While reset is held low, every `core_cs` bit is 0 and `host_rdata` is 0.
- R2: The address splits into a core number and an offset. The core number is `host_addr[OFS_W+CORE_W-1:OFS_W]` and the offset is `host_addr[OFS_W-1:0]`. Take a fast cycle in which `host_cs` is high and the core number k is below `NUM_CORES`. On the next fast cycle, `core_cs[k]` is high. In that same cycle, `core_we[k]` equals `host_we`, and core k's slices of `core_addr` and `core_wdata` carry that cycle's offset and `host_wdata`.
- R3: At most one `core_cs` bit is high in any cycle.
- R4: A request whose core number is `NUM_CORES` or above raises no `core_cs` bit on the next cycle. A write to such a number changes no core's storage.
- R5: Consider a request presented just after fast edge c and held for two fast cycles. From fast edge c+3 until at least edge c+4, `host_rdata` equals the read bus of the addressed core at the forwarded offset. A read issued right after a write returns the newly written value.
- R6: A read whose core number is `NUM_CORES` or above returns 0 in the same window as R5.
- R7: The offset and write data held for a core do not change while other cores are being addressed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock shared with the cores |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_cs | input | 1 | Host request active, held for two fast cycles |
| host_we | input | 1 | 1 = write, 0 = read |
| host_addr | input | CORE_W+OFS_W | Core number in the upper field, register offset in the lower field |
| host_wdata | input | DATA_W | Write data from the host |
| host_rdata | output | DATA_W | Registered read data of the addressed core |
| core_cs | output | NUM_CORES | Per-core registered select |
| core_we | output | NUM_CORES | Per-core write strobe, qualified by its select |
| core_addr | output | NUM_CORES*OFS_W | Per-core registered offsets, core k at bits k*OFS_W and up |
| core_wdata | output | NUM_CORES*DATA_W | Per-core registered write data, core k at bits k*DATA_W and up |
| core_rdata | input | NUM_CORES*DATA_W | Per-core read buses, core k at bits k*DATA_W and up |

## Verification
The assertions assume that the host changes its request only on slow-clock boundaries. They also assume that each core's read bus depends only on its own registered offset and its storage. The routing and drop properties compare each select with the address of the previous fast cycle. The zero-readback property looks back exactly three fast cycles, which holds only when requests stay stable over whole slow cycles. The stimulus drives requests on a falling edge and holds each for exactly two fast cycles, back to back. Model cores in the bench answer from their own registered offset.

// File: rtl/xbar_pkg.sv
package xbar_pkg;
  localparam int XB_NUM_CORES = 4;
  localparam int XB_CORE_W    = 6;
  localparam int XB_OFS_W     = 8;
  localparam int XB_DATA_W    = 32;

  // true when a core number (zero-extended) points at a populated core
  function automatic logic core_populated(input int unsigned num, input int unsigned count);
    return num < count;
  endfunction
endpackage

// File: rtl/xbar_req_lane.sv
module xbar_req_lane #(
  parameter int OFS_W  = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel,
  input  logic              we,
  input  logic [OFS_W-1:0]  ofs,
  input  logic [DATA_W-1:0] wdata,
  output logic              cs_q,
  output logic              we_q,
  output logic [OFS_W-1:0]  ofs_q,
  output logic [DATA_W-1:0] wdata_q
);
  // private copy of the request for one core; loads only when addressed
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_q    <= 1'b0;
      we_q    <= 1'b0;
      ofs_q   <= '0;
      wdata_q <= '0;
    end else begin
      cs_q <= sel;
      if (sel) begin
        we_q    <= we;
        ofs_q   <= ofs;
        wdata_q <= wdata;
      end
    end
  end
endmodule

// File: rtl/xbar_write_fanout.sv
module xbar_write_fanout #(
  parameter int NUM_CORES = 4,
  parameter int CORE_W    = 6,
  parameter int OFS_W     = 8,
  parameter int DATA_W    = 32
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        host_cs,
  input  logic                        host_we,
  input  logic [CORE_W-1:0]           core_num,
  input  logic [OFS_W-1:0]            host_ofs,
  input  logic [DATA_W-1:0]           host_wdata,
  output logic [NUM_CORES-1:0]        core_cs,
  output logic [NUM_CORES-1:0]        core_we,
  output logic [NUM_CORES*OFS_W-1:0]  core_addr,
  output logic [NUM_CORES*DATA_W-1:0] core_wdata
);
  import xbar_pkg::*;

  logic                 hit;
  logic [NUM_CORES-1:0] sel;

  function automatic logic [NUM_CORES-1:0] decode_sel(input logic valid,
                                                       input logic [CORE_W-1:0] num);
    logic [NUM_CORES-1:0] r;
    r = '0;
    for (int k = 0; k < NUM_CORES; k++)
      if (valid && num == CORE_W'(k)) r[k] = 1'b1;
    return r;
  endfunction

  assign hit = host_cs && core_populated(32'(core_num), NUM_CORES);
  assign sel = decode_sel(hit, core_num);

  for (genvar k = 0; k < NUM_CORES; k++) begin : g_lane
    logic cs_q, we_q;
    xbar_req_lane #(.OFS_W(OFS_W), .DATA_W(DATA_W)) u_lane (
      .clk     (clk),
      .rst_n   (rst_n),
      .sel     (sel[k]),
      .we      (host_we),
      .ofs     (host_ofs),
      .wdata   (host_wdata),
      .cs_q    (cs_q),
      .we_q    (we_q),
      .ofs_q   (core_addr[k*OFS_W +: OFS_W]),
      .wdata_q (core_wdata[k*DATA_W +: DATA_W])
    );
    assign core_cs[k] = cs_q;
    assign core_we[k] = cs_q & we_q;
  end
endmodule

// File: rtl/xbar_read_mux.sv
module xbar_read_mux #(
  parameter int NUM_CORES = 4,
  parameter int CORE_W    = 6,
  parameter int DATA_W    = 32
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [CORE_W-1:0]           core_num,
  input  logic [NUM_CORES*DATA_W-1:0] core_rdata,
  output logic [DATA_W-1:0]           rdata_q
);
  import xbar_pkg::*;

  logic [CORE_W-1:0] num_d1, num_d2;
  logic [DATA_W-1:0] mux_out;

  // wide selection; an unpopulated number yields zero
  function automatic logic [DATA_W-1:0] pick(input logic [CORE_W-1:0] num,
                                             input logic [NUM_CORES*DATA_W-1:0] bus);
    logic [DATA_W-1:0] r;
    r = '0;
    for (int k = 0; k < NUM_CORES; k++)
      if (num == CORE_W'(k)) r = bus[k*DATA_W +: DATA_W];
    return r;
  endfunction

  // two select stages line the mux select up with the lane offset registers
  // and give the data and select paths a two-cycle budget
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      num_d1 <= '0;
      num_d2 <= '0;
    end else begin
      num_d1 <= core_num;
      num_d2 <= num_d1;
    end
  end

  assign mux_out = core_populated(32'(num_d2), NUM_CORES) ? pick(num_d2, core_rdata) : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdata_q <= '0;
    else        rdata_q <= mux_out;
  end
endmodule

// File: rtl/core_selector_xbar.sv
module core_selector_xbar #(
  parameter int NUM_CORES = xbar_pkg::XB_NUM_CORES,
  parameter int CORE_W    = xbar_pkg::XB_CORE_W,
  parameter int OFS_W     = xbar_pkg::XB_OFS_W,
  parameter int DATA_W    = xbar_pkg::XB_DATA_W
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        host_cs,
  input  logic                        host_we,
  input  logic [CORE_W+OFS_W-1:0]     host_addr,
  input  logic [DATA_W-1:0]           host_wdata,
  output logic [DATA_W-1:0]           host_rdata,
  output logic [NUM_CORES-1:0]        core_cs,
  output logic [NUM_CORES-1:0]        core_we,
  output logic [NUM_CORES*OFS_W-1:0]  core_addr,
  output logic [NUM_CORES*DATA_W-1:0] core_wdata,
  input  logic [NUM_CORES*DATA_W-1:0] core_rdata
);
  logic [CORE_W-1:0] core_num;
  logic [OFS_W-1:0]  host_ofs;

  assign core_num = host_addr[OFS_W +: CORE_W];
  assign host_ofs = host_addr[OFS_W-1:0];

  xbar_write_fanout #(
    .NUM_CORES(NUM_CORES), .CORE_W(CORE_W), .OFS_W(OFS_W), .DATA_W(DATA_W)
  ) u_fanout (
    .clk        (clk),
    .rst_n      (rst_n),
    .host_cs    (host_cs),
    .host_we    (host_we),
    .core_num   (core_num),
    .host_ofs   (host_ofs),
    .host_wdata (host_wdata),
    .core_cs    (core_cs),
    .core_we    (core_we),
    .core_addr  (core_addr),
    .core_wdata (core_wdata)
  );

  xbar_read_mux #(
    .NUM_CORES(NUM_CORES), .CORE_W(CORE_W), .DATA_W(DATA_W)
  ) u_rmux (
    .clk        (clk),
    .rst_n      (rst_n),
    .core_num   (core_num),
    .core_rdata (core_rdata),
    .rdata_q    (host_rdata)
  );
endmodule

// File: rtl/xbar_chk.sv
module xbar_chk #(
  parameter int NUM_CORES = 4,
  parameter int CORE_W    = 6,
  parameter int OFS_W     = 8,
  parameter int DATA_W    = 32
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic                        host_cs,
  input logic                        host_we,
  input logic [CORE_W+OFS_W-1:0]     host_addr,
  input logic [DATA_W-1:0]           host_wdata,
  input logic [DATA_W-1:0]           host_rdata,
  input logic [NUM_CORES-1:0]        core_cs,
  input logic [NUM_CORES-1:0]        core_we,
  input logic [NUM_CORES*OFS_W-1:0]  core_addr,
  input logic [NUM_CORES*DATA_W-1:0] core_wdata,
  input logic [NUM_CORES*DATA_W-1:0] core_rdata
);
  localparam logic [CORE_W:0] NUM_L = (CORE_W+1)'(NUM_CORES);

  logic [CORE_W-1:0] num;
  logic              unpop;
  logic              req_ok, req_bad;
  logic [1:0]        age;

  assign num     = host_addr[OFS_W +: CORE_W];
  assign unpop   = {1'b0, num} >= NUM_L;
  assign req_ok  = host_cs && !unpop;
  assign req_bad = host_cs && unpop;

  function automatic logic [NUM_CORES-1:0] one_of(input logic [CORE_W-1:0] n);
    logic [NUM_CORES-1:0] r;
    r = '0;
    for (int k = 0; k < NUM_CORES; k++)
      if (n == CORE_W'(k)) r[k] = 1'b1;
    return r;
  endfunction

  // cycles since reset, saturating, so three-deep history is only used once filled
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        age <= '0;
    else if (age != 3) age <= age + 2'd1;
  end

  // R3
  cs_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(core_cs));

  // R2
  cs_route_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_ok |=> core_cs == one_of($past(num)));

  // R4
  cs_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_bad |=> core_cs == '0);

  // R6
  zero_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (age == 3 && $past(unpop, 3)) |-> host_rdata == '0);

  for (genvar k = 0; k < NUM_CORES; k++) begin : g_lane_chk
    // R2
    lane_payload_chk: assert property (@(posedge clk) disable iff (!rst_n)
      core_cs[k] |-> (core_addr[k*OFS_W +: OFS_W] == $past(host_addr[OFS_W-1:0])
                      && core_wdata[k*DATA_W +: DATA_W] == $past(host_wdata)
                      && core_we[k] == $past(host_we)));
    // R7
    lane_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !core_cs[k] |-> $stable(core_addr[k*OFS_W +: OFS_W]));
  end
endmodule

bind core_selector_xbar xbar_chk #(
  .NUM_CORES(NUM_CORES), .CORE_W(CORE_W), .OFS_W(OFS_W), .DATA_W(DATA_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .host_cs(host_cs), .host_we(host_we),
  .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
  .core_cs(core_cs), .core_we(core_we), .core_addr(core_addr),
  .core_wdata(core_wdata), .core_rdata(core_rdata)
);

// File: tb/core_selector_xbar_tb.sv
module core_selector_xbar_tb;
  localparam int N  = 4;
  localparam int CW = 6;
  localparam int OW = 8;
  localparam int DW = 32;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              host_cs = 1'b0, host_we = 1'b0;
  logic [CW+OW-1:0]  host_addr = '0;
  logic [DW-1:0]     host_wdata = '0;
  logic [DW-1:0]     host_rdata;
  logic [N-1:0]      core_cs, core_we;
  logic [N*OW-1:0]   core_addr;
  logic [N*DW-1:0]   core_wdata, core_rdata;

  int errors = 0, checks = 0, cyc = 0;
  bit done = 0;

  logic [DW-1:0] mem    [N][256];
  logic [DW-1:0] shadow [N][256];

  int            wq_core[$], wq_ofs[$];
  logic [DW-1:0] wq_dat[$];
  logic [DW-1:0] rq_exp[$];
  int            rq_due[$];
  string         rq_tag[$];

  core_selector_xbar #(.NUM_CORES(N), .CORE_W(CW), .OFS_W(OW), .DATA_W(DW)) u_dut (
    .clk(clk), .rst_n(rst_n), .host_cs(host_cs), .host_we(host_we),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .core_cs(core_cs), .core_we(core_we), .core_addr(core_addr),
    .core_wdata(core_wdata), .core_rdata(core_rdata)
  );

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  // model cores: storage written on strobe, read from own registered offset
  for (genvar k = 0; k < N; k++) begin : g_core
    assign core_rdata[k*DW +: DW] = mem[k][core_addr[k*OW +: OW]];
  end
  always @(posedge clk)
    for (int k = 0; k < N; k++)
      if (core_cs[k] && core_we[k]) mem[k][core_addr[k*OW +: OW]] <= core_wdata[k*DW +: DW];

  task automatic check(input bit ok, input string tag, input logic [DW-1:0] act,
                       input logic [DW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  // driver: one request per slow cycle, held two fast cycles
  task automatic req(input bit we, input int core, input int ofs, input logic [DW-1:0] d);
    host_cs    = 1'b1;
    host_we    = we;
    host_addr  = {CW'(core), OW'(ofs)};
    host_wdata = d;
    if (we && core < N) begin
      for (int r = 0; r < 2; r++) begin
        wq_core.push_back(core); wq_ofs.push_back(ofs); wq_dat.push_back(d);
      end
      shadow[core][ofs] = d;
    end
    if (!we) begin
      rq_exp.push_back(core < N ? shadow[core][ofs] : '0);
      rq_due.push_back(cyc + 3);
      rq_tag.push_back(core < N ? "R5 readback" : "R6 unpopulated read");
    end
    @(negedge clk); @(negedge clk);
  endtask

  task automatic idle(input int n);
    host_cs = 1'b0; host_we = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  // monitor: pops expected items as the design produces them
  always @(negedge clk) if (rst_n) begin
    check($countones(core_cs) <= 1, "R3 one select", DW'(core_cs), '0);
    for (int k = 0; k < N; k++)
      if (core_cs[k] && core_we[k]) begin
        if (wq_core.size() == 0)
          check(0, "R4 unexpected write strobe", DW'(k), '1);
        else begin
          check(wq_core[0] == k, "R2 write target", DW'(k), DW'(wq_core[0]));
          check(core_addr[k*OW +: OW] == OW'(wq_ofs[0]), "R2 offset",
                DW'(core_addr[k*OW +: OW]), DW'(wq_ofs[0]));
          check(core_wdata[k*DW +: DW] == wq_dat[0], "R2 wdata",
                core_wdata[k*DW +: DW], wq_dat[0]);
          void'(wq_core.pop_front()); void'(wq_ofs.pop_front()); void'(wq_dat.pop_front());
        end
      end
    if (rq_due.size() != 0 && rq_due[0] == cyc) begin
      check(host_rdata == rq_exp[0], rq_tag[0], host_rdata, rq_exp[0]);
      void'(rq_exp.pop_front()); void'(rq_due.pop_front()); void'(rq_tag.pop_front());
    end
  end

  initial begin
    for (int k = 0; k < N; k++)
      for (int a = 0; a < 256; a++) begin
        mem[k][a]    = DW'(k * 1000 + a);
        shadow[k][a] = DW'(k * 1000 + a);
      end
    repeat (3) @(negedge clk);
    // R1
    check(core_cs == '0, "R1 reset selects", DW'(core_cs), '0);
    check(host_rdata == '0, "R1 reset rdata", host_rdata, '0);
    rst_n = 1'b1;
    @(negedge clk);

    // back-to-back writes to every core, then reads
    for (int i = 0; i < 12; i++) req(1, i % N, (i * 37) & 255, 32'hA500_0000 + DW'(i));
    for (int i = 0; i < 12; i++) req(0, i % N, (i * 37) & 255, '0);
    // untouched registers read their initial content
    req(0, 2, 200, '0);
    req(0, 0, 1, '0);
    // write then read the same register immediately
    req(1, 1, 9, 32'hDEAD_BEEF);
    req(0, 1, 9, '0);
    // R7 setup: core 3 last addressed here
    req(1, 3, 8'h55, 32'h3333_5555);
    // R4: write to an unpopulated core number, then show nothing changed
    req(1, 9, 8'h10, 32'hBAD0_BAD0);
    req(1, 63, 8'h10, 32'hBAD1_BAD1);
    req(0, 1, 8'h10, '0);
    req(0, 0, 8'h10, '0);
    // R6: unpopulated reads, interleaved with populated ones
    req(0, 9, 8'h10, '0);
    req(0, 2, 5, '0);
    req(0, N, 0, '0);
    req(0, 63, 255, '0);
    // traffic elsewhere while core 3 is idle
    for (int i = 0; i < 6; i++) req(i[0], i % 3, i + 100, 32'h7000_0000 + DW'(i));
    idle(6);
    // R7
    check(core_addr[3*OW +: OW] == 8'h55, "R7 held offset",
          DW'(core_addr[3*OW +: OW]), 32'h55);
    check(core_wdata[3*DW +: DW] == 32'h3333_5555, "R7 held wdata",
          core_wdata[3*DW +: DW], 32'h3333_5555);
    // R2: every expected write strobe appeared
    check(wq_core.size() == 0, "R2 all writes delivered", DW'(wq_core.size()), '0);
    // R5: every expected read was sampled
    check(rq_due.size() == 0, "R5 all reads sampled", DW'(rq_due.size()), '0);
    // R4: storage at the dropped offset still holds initial values
    for (int k = 0; k < N; k++)
      check(mem[k][8'h10] == shadow[k][8'h10], "R4 storage untouched",
            mem[k][8'h10], shadow[k][8'h10]);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired actual=%0d expected=done", cyc);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule